// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is a memory-mapped SPI master that exchanges exactly one byte per start command and holds no FIFO. Software loads a transmit byte, sets the start bit, and the block shifts the byte out on MOSI while capturing MISO. When the eighth bit is done, the received byte is posted and a ready flag is raised. The interrupt output follows that flag, so the host handles one interrupt per byte.

A mode register selects the idle level of SCK, which edge latches data, the bit order, port enable and an internal loopback path. An 8-bit divisor sets the serial clock rate. The register bus is a plain strobe bus (address, write strobe, read strobe, write data, read data) that completes every access in one cycle. It never stalls, so it has no ready signal and no back-pressure.

Top module: `spim_byte_master`

## Requirements
- R1: After reset, every register reads 0x00, SCK and MOSI are low and the interrupt is low.
- R2: Byte offsets are: mode 0, receive data 1, transmit data 2, control 3, status 4, divisor 6. Offset 5 reads 0x00. The mode register stores only bits 0x1F and reads back those bits. The divisor reads back its full 8 bits. Writes to receive data and status have no effect.
- R3: Writing a value with bit 0x01 set to control (offset 3) starts a transfer of the transmit register when mode bit 0x08 (enable) is set. While the transfer runs, status bit 0x02 (busy) reads 1.
- R4: A start command is ignored while mode bit 0x08 is clear or while busy is set. Ignored means no SCK edges, no change to status, and the running transfer is unaffected.
- R5: Each transfer produces exactly 8 SCK cycles. The SCK period is 4×(divisor+1) system clocks.
- R6: Whenever no transfer is active, SCK rests at the level of mode bit 0x02 (1 = idle high).
- R7: With mode bit 0x10 = 1, data is latched on the leading SCK edge and MOSI changes on the trailing edge, with the first bit valid before the first edge. With 0x10 = 0, MOSI changes on the leading edge and data is latched on the trailing edge.
- R8: With mode bit 0x04 clear, bits go MSB first on both MOSI and MISO. With 0x04 set, they go LSB first.
- R9: With mode bit 0x01 set, MOSI is looped back internally in place of MISO, so the received byte equals the transmitted byte.
- R10: On completion, the received byte appears at offset 1, status bit 0x01 (ready) and the interrupt rise together, and busy reads 1 in that cycle and 0 one cycle later.
- R11: Reading offset 1 clears ready and the interrupt. An accepted start command also clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt, high while a received byte is waiting |

## Verification
The bench builds the block with its default widths: an 8-bit byte and an 8-bit divisor. These defaults bring the full divisor range within reach, including the slowest setting 255, where one byte takes 8192 clocks, alongside divisors 0, 2 and 3. A bench-side SPI slave runs in all four edge/polarity combinations and in both bit orders. It checks the MOSI stream, SCK edge count and period, while status is polled every cycle to catch the one-cycle gap between ready and busy falling. Starts issued while disabled or while busy are shown to produce no extra edges.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // register byte offsets
  localparam int OFS_MODE = 0;
  localparam int OFS_RXD  = 1;
  localparam int OFS_TXD  = 2;
  localparam int OFS_CTRL = 3;
  localparam int OFS_STAT = 4;
  localparam int OFS_DIV  = 6;

  // mode register bit positions
  localparam int MB_LOOP = 0;
  localparam int MB_CPOL = 1;
  localparam int MB_LSB  = 2;
  localparam int MB_EN   = 3;
  localparam int MB_LEAD = 4;
  localparam int MODE_W  = 5;

  // control and status bit positions
  localparam int CB_GO   = 0;
  localparam int SB_RDY  = 0;
  localparam int SB_BUSY = 1;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  // one tick per SCK half period: 2*(div+1) clocks
  logic [DIV_W:0] cnt_q;
  logic [DIV_W:0] lim;

  assign lim  = {div, 1'b1};
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q == lim) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= lim); // R5
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              cpol,
  input  logic              lead,
  input  logic              lsb,
  input  logic              loop,
  input  logic [DATA_W-1:0] tx,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              active,
  output logic              done,
  output logic [DATA_W-1:0] rx
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [DATA_W-1:0] tx_rev, rx_rev, tx_ord;
  logic [DATA_W-1:0] txs_q, rxs_q;
  logic [EW-1:0]     ecnt_q;
  logic              act_q, sck_q, mosi_q, done_q;
  logic              leading, sample_now, drive_now, miso_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign tx_rev[i] = tx[DATA_W-1-i];
    assign rx_rev[i] = rxs_q[DATA_W-1-i];
  end

  assign tx_ord     = lsb ? tx_rev : tx;
  assign miso_in    = loop ? mosi_q : miso;
  assign leading    = ~ecnt_q[0];
  assign sample_now = tick && (leading == lead);
  assign drive_now  = tick && (leading != lead) && (ecnt_q != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ecnt_q <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        sck_q <= cpol;
        if (start) begin
          act_q  <= 1'b1;
          ecnt_q <= '0;
          rxs_q  <= '0;
          if (lead) begin
            mosi_q <= tx_ord[DATA_W-1];
            txs_q  <= tx_ord << 1;
          end else begin
            txs_q  <= tx_ord;
          end
        end
      end else if (tick) begin
        sck_q  <= ~sck_q;
        ecnt_q <= ecnt_q + 1'b1;
        if (sample_now) rxs_q <= {rxs_q[DATA_W-2:0], miso_in};
        if (drive_now) begin
          mosi_q <= txs_q[DATA_W-1];
          txs_q  <= txs_q << 1;
        end
        if (ecnt_q == LAST) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sck    = sck_q;
  assign mosi   = mosi_q;
  assign active = act_q;
  assign done   = done_q;
  assign rx     = lsb ? rx_rev : rxs_q;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && $past(!act_q) && $stable(cpol)) |-> sck_q == cpol); // R6
  AST_END_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $stable(cpol)) |-> sck_q == cpol); // R5
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(act_q) && !act_q); // R10
endmodule

// File: rtl/spim_byte_master.sv
module spim_byte_master
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  logic [MODE_W-1:0] mode_q;
  logic [DATA_W-1:0] txd_q, rxd_q, eng_rx;
  logic [DIV_W-1:0]  div_q;
  logic              rdy_q, busy_q, done_d;
  logic              go, tick, eng_act, eng_done, rx_rd;

  assign go = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL)) && bus_wdata[CB_GO]
              && mode_q[MB_EN] && !busy_q;
  assign rx_rd = bus_rd && (bus_addr == ADDR_W'(OFS_RXD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      txd_q  <= '0;
      rxd_q  <= '0;
      div_q  <= '0;
      rdy_q  <= 1'b0;
      busy_q <= 1'b0;
      done_d <= 1'b0;
    end else begin
      done_d <= eng_done;
      if (bus_wr) begin
        if (bus_addr == ADDR_W'(OFS_MODE)) mode_q <= bus_wdata[MODE_W-1:0];
        if (bus_addr == ADDR_W'(OFS_TXD))  txd_q  <= bus_wdata;
        if (bus_addr == ADDR_W'(OFS_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
      end
      if (go)          busy_q <= 1'b1;
      else if (done_d) busy_q <= 1'b0;
      if (eng_done) rxd_q <= eng_rx;
      if (go)            rdy_q <= 1'b0;
      else if (eng_done) rdy_q <= 1'b1;
      else if (rx_rd)    rdy_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_MODE): bus_rdata = DATA_W'(mode_q);
      ADDR_W'(OFS_RXD):  bus_rdata = rxd_q;
      ADDR_W'(OFS_TXD):  bus_rdata = txd_q;
      ADDR_W'(OFS_STAT): bus_rdata = DATA_W'({busy_q, rdy_q});
      ADDR_W'(OFS_DIV):  bus_rdata = DATA_W'(div_q);
      default:           bus_rdata = '0;
    endcase
  end

  spim_baud #(.DIV_W(DIV_W)) i_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_act),
    .div  (div_q),
    .tick (tick)
  );

  spim_shift #(.DATA_W(DATA_W)) i_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go),
    .tick  (tick),
    .cpol  (mode_q[MB_CPOL]),
    .lead  (mode_q[MB_LEAD]),
    .lsb   (mode_q[MB_LSB]),
    .loop  (mode_q[MB_LOOP]),
    .tx    (txd_q),
    .miso  (miso),
    .sck   (sck),
    .mosi  (mosi),
    .active(eng_act),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  assign irq = rdy_q;

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(mode_q[MB_EN])); // R4
  AST_ENGINE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_act |-> busy_q); // R3
  AST_RDY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |-> busy_q); // R10
  AST_BUSY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_q) |=> !busy_q); // R10
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !eng_done) |=> !irq); // R11
endmodule

// File: tb/test_spim_byte_master.sv
module test_spim_byte_master;
  localparam int CP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, mosi, irq;
  logic       miso = 1'b0;

  int n_cmp = 0, n_bad = 0;

  // slave model state
  logic       s_cpol = 0, s_lead = 1, s_lsb = 0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_k = 0, s_j = 0, lead_cnt = 0, cyc = 0, last_lead = 0, period = 0;
  logic       prev_sck = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CP/2) clk = ~clk;

  spim_byte_master i_spim_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bwrite(int a, int d);
    @(negedge clk); addr = 3'(a); wdata = 8'(d); wr = 1'b1; rd = 1'b0;
  endtask

  task automatic bread(int a, output logic [7:0] v);
    @(negedge clk); addr = 3'(a); wr = 1'b0; rd = 1'b1;
    #(CP/4) v = rdata;
  endtask

  task automatic bidle();
    @(negedge clk); wr = 1'b0; rd = 1'b0;
  endtask

  task automatic slave_bit();
    if (s_k < 8) miso = s_lsb ? s_tx[s_k] : s_tx[7-s_k];
    s_k++;
  endtask

  // monitor: bench-side SPI slave, pops expected MOSI bytes
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (sck !== prev_sck) begin
        if (prev_sck == s_cpol) begin
          lead_cnt++;
          if (lead_cnt > 1) period = cyc - last_lead;
          last_lead = cyc;
        end
        if ((prev_sck == s_cpol) == s_lead) begin
          if (s_lsb) s_rx[s_j] = mosi; else s_rx[7-s_j] = mosi;
          s_j++;
          if (s_j == 8) begin
            if (exp_q.size() == 0) begin
              n_cmp++; n_bad++;
              $display("FAIL R4: actual extra byte 0x%0h expected none", s_rx);
            end else chk(tag_q.pop_front(), s_rx, exp_q.pop_front());
            s_j = 0;
          end
        end else if (s_j > 0 || !s_lead) slave_bit();
        prev_sck = sck;
      end
    end
  end

  task automatic arm(int mode, int dv, int tx, int slv, string tag);
    logic [7:0] v;
    bwrite(0, mode); bwrite(6, dv); bwrite(2, tx);
    s_cpol = mode[1]; s_lead = mode[4]; s_lsb = mode[2];
    s_tx = 8'(slv); s_k = 0; s_j = 0; lead_cnt = 0; period = 0;
    prev_sck = s_cpol;
    if (s_lead) slave_bit();
    exp_q.push_back(8'(tx)); tag_q.push_back(tag);
    bwrite(3, 1);
    bread(4, v);
    chk("R3 busy after start", v, 8'h02);
  endtask

  task automatic finish(int mode, int dv, int tx, int slv, string tag);
    logic [7:0] v;
    int n = 0;
    v = 0;
    while (!v[0] && n < 20000) begin bread(4, v); n++; end
    chk("R10 first ready status", v, 8'h03);
    chk("R10 irq with ready", irq, 1);
    bread(4, v);
    chk("R10 busy falls next cycle", v, 8'h01);
    bread(1, v);
    chk({tag, " received byte"}, v, mode[0] ? tx : slv);
    bidle();
    chk("R11 irq cleared by rx read", irq, 0);
    bread(4, v);
    chk("R11 ready cleared", v, 8'h00);
    bidle();
    chk("R5 eight sck cycles", lead_cnt, 8);
    chk("R5 sck period", period, 4 * (dv + 1));
    chk("R6 sck idle level", sck, mode[1]);
  endtask

  task automatic xfer(int mode, int dv, int tx, int slv, string tag);
    arm(mode, dv, tx, slv, tag);
    finish(mode, dv, tx, slv, tag);
  endtask

  initial begin
    #(CP * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    chk("R1 sck", sck, 0); chk("R1 mosi", mosi, 0); chk("R1 irq", irq, 0);
    for (int a = 0; a < 8; a++) begin bread(a, v); chk("R1 reg reset", v, 0); end
    // R2 map and readback
    bwrite(0, 8'hFF); bread(0, v); chk("R2 mode holds 0x1F", v, 8'h1F);
    bwrite(0, 8'h00);
    bwrite(6, 8'hA5); bread(6, v); chk("R2 divisor", v, 8'hA5);
    bwrite(2, 8'h3C); bread(2, v); chk("R2 txd", v, 8'h3C);
    bwrite(5, 8'h77); bread(5, v); chk("R2 unused offset", v, 0);
    bwrite(1, 8'h99); bread(1, v); chk("R2 rxd not writable", v, 0);
    bwrite(4, 8'hFF); bread(4, v); chk("R2 status not writable", v, 0);
    bidle();
    // R4 start ignored with enable clear
    bwrite(0, 8'h02); bwrite(3, 1); bidle(); lead_cnt = 0; s_cpol = 1;
    repeat (60) @(posedge clk);
    bread(4, v); bidle();
    chk("R4 disabled start ignored", v, 0);
    chk("R4 no sck edges", lead_cnt, 0);
    chk("R6 idle high", sck, 1);
    // R7 four clock modes, MSB first
    xfer(8'h18, 0, 8'hA5, 8'h3C, "R7 mode0");
    xfer(8'h08, 2, 8'h5A, 8'hC3, "R7 mode1");
    xfer(8'h1A, 0, 8'h81, 8'h7E, "R7 mode2");
    xfer(8'h0A, 3, 8'h12, 8'hED, "R7 mode3");
    // R8 LSB first
    xfer(8'h1C, 0, 8'h01, 8'h80, "R8 lsb mode0");
    xfer(8'h0E, 1, 8'hC8, 8'h35, "R8 lsb mode3");
    // R9 loopback, slave drives other data
    xfer(8'h19, 0, 8'h6B, 8'h00, "R9 loopback");
    xfer(8'h0D, 0, 8'hD2, 8'hFF, "R9 loopback lsb");
    // R5 slowest divisor
    xfer(8'h18, 255, 8'hF0, 8'h0F, "R5 div255");
    // R4 start while busy ignored
    arm(8'h18, 3, 8'h44, 8'hBB, "R4 busy keeps byte");
    repeat (20) @(posedge clk);
    bwrite(2, 8'h11); bwrite(3, 1); bidle();
    finish(8'h18, 3, 8'h44, 8'hBB, "R4 busy keeps byte");
    repeat (100) @(posedge clk);
    bread(4, v); bidle();
    chk("R4 no restart after busy start", v, 0);
    // R11 new start clears pending ready
    xfer(8'h18, 0, 8'h22, 8'h99, "R10 first byte");
    arm(8'h18, 0, 8'h33, 8'h66, "R11 second byte");
    v = 0;
    while (!v[0]) bread(4, v);
    bidle();
    chk("R10 irq raised", irq, 1);
    arm(8'h18, 0, 8'h55, 8'hAA, "R11 restart");
    chk("R11 irq cleared by start", irq, 0);
    finish(8'h18, 0, 8'h55, 8'hAA, "R11 restart");
    repeat (10) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule